// File: doc/BRIEF.md
# Crystal-to-seconds prescaler with programmable compare

This block sits at the front of a real-time clock. It divides a free-running crystal clock down to one pulse per second and keeps a running count of those seconds. It uses one of two counting methods. The fixed method assumes a 32768 Hz crystal and divides by 2^15. The compare method divides by a programmable value plus one, so crystals from 32000 Hz up to 2^22 Hz can be used. Software loads a 22-bit terminal value equal to the crystal rate minus one.

Software works through a small register port in the bus clock domain. The run request is carried into the crystal domain through a synchronizer. The value actually in effect there is carried back through a second synchronizer and appears as a read-only running flag. Software stops the counter and waits for that flag to clear before it changes the counting method or the compare value. While the counter may be running, the block drops such writes. A 12/24-hour selection bit is stored and passed to later calendar logic.

Top module: `rtc_tick_gen`

## Requirements
- R1: After reset, the control register (offset 0x00) and the compare register (offset 0x3C) read 0, `sec_count` is 0 and `sec_tick` is low.
- R2: Control bit 7 is the run request, bit 5 the 24-hour select (driven on `mode_24h`) and bit 4 the method select; these read back as written. Bit 6 is read-only, and writes to it have no effect. A read returns data on `reg_rdata` one bus cycle after `reg_rd`, and unused bits read 0.
- R3: Control bit 6 reads 1 once the crystal domain is running. After the run request is cleared, bit 6 returns to 0 within 2 to 4 crystal cycles, plus at most one bus cycle of read latency.
- R4: With method select 0, `sec_tick` pulses once every 32768 crystal cycles.
- R5: With method select 1, `sec_tick` pulses once every N+1 crystal cycles, where N is the compare value. The compare register is 22 bits wide, and bits above bit 21 read 0.
- R6: `sec_tick` is high for a single crystal cycle, unless the compare method is used with N = 0.
- R7: `sec_count` rises by exactly one, modulo 2^32, in the crystal cycle of each tick and holds its value otherwise.
- R8: Writes to the method bit or to the compare register are ignored while the run request or the running flag reads 1. This includes a control write that clears the run request in the same access.
- R9: Each start restarts the sub-second count from zero. The first tick after a start therefore comes N+1 crystal cycles after the start reaches the crystal domain, whatever count was reached before the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| xtal_clk | input | 1 | Crystal clock |
| xtal_rst | input | 1 | Synchronous active-high reset, crystal domain |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| sec_tick | output | 1 | One-crystal-cycle pulse per second |
| sec_count | output | 32 | Free-running seconds count |
| mode_24h | output | 1 | Stored 24-hour select for calendar logic |

## Verification
The tightest collision is a stop and a configuration change arriving in the same bus access. The bench issues one control write that clears the run request and also flips the method bit. It then reads the control register back and expects the old method to be kept, because the lock is judged on the state before the write. In the crystal domain, the tick and the seconds increment share a cycle. The scoreboard therefore compares each tick's interval against a queued expectation and checks the count in that same sampled cycle.

// File: rtl/rtc_pre_pkg.sv
`timescale 1ns/1ps
package rtc_pre_pkg;
  // register byte offsets
  localparam int CTRL_OFS = 'h00;
  localparam int CMP_OFS  = 'h3C;
  // control field positions
  localparam int EN_BIT   = 7;
  localparam int STAT_BIT = 6;
  localparam int H24_BIT  = 5;
  localparam int MODE_BIT = 4;

  typedef struct packed {
    logic run_req;
    logic h24;
    logic use_cmp;
  } ctrl_t;
endpackage

// File: rtl/rtc_sync.sv
`timescale 1ns/1ps
module rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_bus_regs.sv
`timescale 1ns/1ps
module rtc_bus_regs
  import rtc_pre_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int CMP_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             running,
  output logic [DW-1:0]    rdata,
  output ctrl_t            ctrl,
  output logic [CMP_W-1:0] cmp_val
);
  logic          locked;
  logic          hit_ctrl, hit_cmp;
  logic [DW-1:0] rd_mux;
  logic          unused_wbits;

  assign locked   = ctrl.run_req | running;
  assign hit_ctrl = (addr == AW'(CTRL_OFS));
  assign hit_cmp  = (addr == AW'(CMP_OFS));
  assign unused_wbits = ^wdata[DW-1:CMP_W];

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[EN_BIT]   = ctrl.run_req;
      rd_mux[STAT_BIT] = running;
      rd_mux[H24_BIT]  = ctrl.h24;
      rd_mux[MODE_BIT] = ctrl.use_cmp;
    end else if (hit_cmp) begin
      rd_mux[CMP_W-1:0] = cmp_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      cmp_val <= '0;
      rdata   <= '0;
    end else begin
      if (wr && hit_ctrl) begin
        ctrl.run_req <= wdata[EN_BIT];
        ctrl.h24     <= wdata[H24_BIT];
        if (!locked) ctrl.use_cmp <= wdata[MODE_BIT];
      end
      if (wr && hit_cmp && !locked) cmp_val <= wdata[CMP_W-1:0];
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rtc_subsec_div.sv
`timescale 1ns/1ps
module rtc_subsec_div #(
  parameter int CMP_W = 22,
  parameter int FIX_W = 15,
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             use_cmp,
  input  logic [CMP_W-1:0] cmp_val,
  output logic             tick,
  output logic [SEC_W-1:0] sec_count,
  output logic [CMP_W-1:0] sub_cnt
);
  localparam logic [CMP_W-1:0] FIX_TERM = CMP_W'((64'd1 << FIX_W) - 64'd1);

  logic [CMP_W-1:0] term;
  logic             at_term;

  assign term    = use_cmp ? cmp_val : FIX_TERM;
  assign at_term = (sub_cnt == term);

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_cnt   <= '0;
      tick      <= 1'b0;
      sec_count <= '0;
    end else begin
      tick <= 1'b0;
      if (!run) begin
        sub_cnt <= '0;
      end else if (at_term) begin
        sub_cnt   <= '0;
        tick      <= 1'b1;
        sec_count <= sec_count + SEC_W'(1);
      end else begin
        sub_cnt <= sub_cnt + CMP_W'(1);
      end
    end
  end
endmodule

// File: rtl/rtc_tick_gen.sv
`timescale 1ns/1ps
module rtc_tick_gen
  import rtc_pre_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int CMP_W  = 22,
  parameter int FIX_W  = 15,
  parameter int SEC_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_clk,
  input  logic             xtal_rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             sec_tick,
  output logic [SEC_W-1:0] sec_count,
  output logic             mode_24h
);
  ctrl_t            ctrl;
  logic [CMP_W-1:0] cmp_val;
  logic [CMP_W-1:0] sub_cnt;
  logic             run_x;
  logic             status_b;
  logic             run_req_b;
  logic             use_cmp_b;

  assign run_req_b = ctrl.run_req;
  assign use_cmp_b = ctrl.use_cmp;
  assign mode_24h  = ctrl.h24;

  rtc_bus_regs #(.AW(AW), .DW(DW), .CMP_W(CMP_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .running(status_b), .rdata(reg_rdata),
    .ctrl(ctrl), .cmp_val(cmp_val)
  );

  // run request into the crystal domain
  rtc_sync #(.STAGES(SYNC_N)) u_sync_run (
    .clk(xtal_clk), .rst(xtal_rst), .d(run_req_b), .q(run_x)
  );

  // effective run state back into the bus domain
  rtc_sync #(.STAGES(SYNC_N)) u_sync_stat (
    .clk(clk), .rst(rst), .d(run_x), .q(status_b)
  );

  rtc_subsec_div #(.CMP_W(CMP_W), .FIX_W(FIX_W), .SEC_W(SEC_W)) u_div (
    .clk(xtal_clk), .rst(xtal_rst), .run(run_x), .use_cmp(use_cmp_b),
    .cmp_val(cmp_val), .tick(sec_tick), .sec_count(sec_count), .sub_cnt(sub_cnt)
  );
endmodule

// File: rtl/rtc_tick_gen_chk.sv
`timescale 1ns/1ps
module rtc_tick_gen_chk #(
  parameter int CMP_W = 22,
  parameter int SEC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             xtal_clk,
  input logic             xtal_rst,
  input logic             run_req,
  input logic             status,
  input logic             use_cmp,
  input logic [CMP_W-1:0] cmp_val,
  input logic             run,
  input logic [CMP_W-1:0] sub_cnt,
  input logic             sec_tick,
  input logic [SEC_W-1:0] sec_count
);
  // R8: configuration frozen while requested or running
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (run_req || status) |=> ($stable(cmp_val) && $stable(use_cmp)));

  // R6: single-cycle tick
  p_tick_pulse_r6: assert property (@(posedge xtal_clk) disable iff (xtal_rst)
    (sec_tick && (!use_cmp || cmp_val != '0)) |=> !sec_tick);

  // R6: a tick only follows a running cycle
  p_tick_needs_run_r6: assert property (@(posedge xtal_clk) disable iff (xtal_rst)
    sec_tick |-> $past(run));

  // R7: seconds advance by one on a tick
  p_count_step_r7: assert property (@(posedge xtal_clk) disable iff (xtal_rst)
    sec_tick |-> (sec_count == $past(sec_count) + SEC_W'(1)));

  // R7: seconds hold without a tick
  p_count_hold_r7: assert property (@(posedge xtal_clk) disable iff (xtal_rst)
    !sec_tick |-> $stable(sec_count));

  // R9: start always from a zero sub-second count
  p_restart_r9: assert property (@(posedge xtal_clk) disable iff (xtal_rst)
    $rose(run) |-> (sub_cnt == '0));

  // R5: compare count never passes its terminal value
  p_sub_bound_r5: assert property (@(posedge xtal_clk) disable iff (xtal_rst)
    (run && use_cmp) |-> (sub_cnt <= cmp_val));
endmodule

bind rtc_tick_gen rtc_tick_gen_chk #(.CMP_W(CMP_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst(rst), .xtal_clk(xtal_clk), .xtal_rst(xtal_rst),
  .run_req(run_req_b), .status(status_b), .use_cmp(use_cmp_b),
  .cmp_val(cmp_val), .run(run_x), .sub_cnt(sub_cnt),
  .sec_tick(sec_tick), .sec_count(sec_count)
);

// File: tb/rtc_tick_gen_tb.sv
`timescale 1ns/1ps
module rtc_tick_gen_tb;
  localparam real BP = 4.0;   // bus period, 250 MHz
  localparam real XP = 5.0;   // crystal period in the bench

  logic        clk = 0, xtal_clk = 0;
  logic        rst = 1, xtal_rst = 1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        sec_tick;
  logic [31:0] sec_count;
  logic        mode_24h;

  always #(BP/2) clk = ~clk;
  always #(XP/2) xtal_clk = ~xtal_clk;

  rtc_tick_gen u_dut (
    .clk(clk), .rst(rst), .xtal_clk(xtal_clk), .xtal_rst(xtal_rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sec_tick(sec_tick), .sec_count(sec_count), .mode_24h(mode_24h)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  int xcyc = 0, last_tick = 0, tick_total = 0;
  logic [31:0] exp_count = 0;
  bit sb_resync = 1, prev_tick = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor / scoreboard, crystal domain
  always @(posedge xtal_clk) begin
    #0.5;
    xcyc++;
    if (!xtal_rst) begin
      if (prev_tick) chk(!sec_tick, "R6 tick width", sec_tick, 0);
      if (sec_tick) begin
        tick_total++;
        exp_count++;
        chk(sec_count == exp_count, "R7 seconds step", sec_count, exp_count);
        if (sb_resync) sb_resync = 0;
        else if (exp_q.size() > 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk((xcyc - last_tick) == e, t, xcyc - last_tick, e);
        end
        last_tick = xcyc;
      end
      prev_tick = sec_tick;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic wait_status(input bit val, input string tag);
    logic [31:0] v;
    bit seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      rd(8'h00, v);
      if (v[6] == val) seen = 1;
    end
    chk(seen, tag, !val, val);
  endtask

  task automatic push(input int n, input int ival, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ival);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_ticks(input int n);
    int target;
    target = tick_total + n;
    wait (tick_total >= target);
  endtask

  // stop and time the fall of the running flag
  task automatic stop_timed(input logic [31:0] ctrl_val);
    real t0, dt;
    bit seen = 0;
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h00; reg_wdata = ctrl_val;
    t0 = $realtime + BP/2;
    @(negedge clk);
    reg_wr = 0; reg_rd = 1;
    dt = 0.0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (!reg_rdata[6]) begin seen = 1; dt = $realtime - t0; end
    end
    reg_rd = 0;
    chk(seen && dt >= 2*XP && dt <= 4*XP + BP + BP/2, "R3 status fall window",
        longint'(dt), longint'(4*XP));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog (all)", 0, 1);
    report();
  end

  initial begin
    logic [31:0] v;
    int x0, d;
    repeat (4) @(posedge xtal_clk);
    @(negedge clk); rst = 0;
    @(negedge xtal_clk); xtal_rst = 0;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(8'h3C, v); chk(v == 0, "R1 compare reset", v, 0);
    chk(sec_count == 0 && !sec_tick, "R1 outputs reset", sec_count, 0);
    rd(8'h10, v); chk(v == 0, "R2 unmapped read", v, 0);

    // R5 compare width
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, v); chk(v == 32'h003F_FFFF, "R5 compare width", v, 32'h003F_FFFF);
    wr(8'h3C, 32'd9);
    rd(8'h3C, v); chk(v == 9, "R5 compare readback", v, 9);

    // R2 start in compare mode, try writing read-only bit 6
    sb_resync = 1;
    wr(8'h00, 32'hF0);
    rd(8'h00, v); chk(v == 32'hB0, "R2 fields, bit6 read-only", v, 32'hB0);
    chk(mode_24h == 1, "R2 mode_24h set", mode_24h, 1);
    wait_status(1, "R3 status rises");
    rd(8'h00, v); chk(v == 32'hF0, "R3 ctrl with status", v, 32'hF0);
    push(3, 10, "R5 interval N=9");
    wait_ticks(4);

    // R8 writes ignored while running
    wr(8'h3C, 32'd4);
    rd(8'h3C, v); chk(v == 9, "R8 compare locked", v, 9);
    wr(8'h00, 32'hA0);
    rd(8'h00, v); chk(v == 32'hF0, "R8 method locked", v, 32'hF0);
    push(2, 10, "R8 interval unchanged");
    wait_ticks(2);

    // R8 stop and method flip in one write: method kept; R3 fall timing
    stop_timed(32'h20);
    rd(8'h00, v); chk(v == 32'h30, "R8 combined stop keeps method", v, 32'h30);

    // R5 new compare accepted when stopped
    wr(8'h3C, 32'd4);
    rd(8'h3C, v); chk(v == 4, "R5 compare write when stopped", v, 4);
    sb_resync = 1;
    wr(8'h00, 32'hB0);
    wait_status(1, "R3 status rises again");
    push(3, 5, "R5 interval N=4");
    wait_ticks(4);

    // R9 restart from zero after a partial count
    wr(8'h00, 32'h30);
    wait_status(0, "R3 status falls");
    wr(8'h3C, 32'd99);
    sb_resync = 1;
    wr(8'h00, 32'hB0);
    wait_ticks(1);
    repeat (60) @(posedge xtal_clk);
    wr(8'h00, 32'h30);
    wait_status(0, "R3 status falls");
    sb_resync = 1;
    wr(8'h00, 32'hB0);
    x0 = xcyc;
    wait_ticks(1);
    d = last_tick - x0;
    chk(d >= 100 && d <= 104, "R9 first tick after restart", d, 102);

    // R4 fixed divider
    wr(8'h00, 32'h30);
    wait_status(0, "R3 status falls");
    sb_resync = 1;
    wr(8'h00, 32'h80);
    chk(mode_24h == 0, "R2 mode_24h cleared", mode_24h, 0);
    rd(8'h00, v); chk(v[4] == 0, "R2 method cleared", v[4], 0);
    push(1, 32768, "R4 fixed interval");
    wait_ticks(2);

    report();
  end
endmodule